// File: doc/BRIEF.md
# Dual-Issue Microinstruction Flag Controller

This block is the control stage of a long-instruction-word vector micro-engine. Each executed cycle it presents a 64-bit word from micro-memory, read at a 12-bit address, and splits it into an upper half for the upper pipe and a lower half for the lower pipe. Five flag bits at the top of the word decide what else happens. The controller owns the run state, a one-instruction delay slot, the interrupt pulse and the write arbitration between the two halves.

Arithmetic is outside this block. Each pipe raises a write request that carries a destination index and a register class. The block returns the enables the register files may use. A single hazard input holds the engine. A coprocessor transfer is captured as a pending entry and written to a control register when a flagged word allows it. The engine is started by a pulse that carries a start address, and it reports busy while it is running.

Top module: `vliw_flag_ctrl`

## Requirements
- R1: The micro-memory address is the low 12 bits of the 16-bit program counter. The upper half of the fetched word (bits 63:32) drives `upper_inst_o` and the lower half (bits 31:0) drives `lower_inst_o`.
- R2: When bit 63 is set in an executed word, only the upper half issues. The lower half is latched into `imm_o` one cycle later, and the lower write enable stays low. Bits 62..59 of that word are ignored.
- R3: When bit 62 is set in an executed word, busy drops after that cycle. The following word still issues as a delay slot, and after it nothing issues and the address holds.
- R4: If a word with bit 62 set executes inside a delay slot, `ebit_in_slot_o` pulses for one cycle after it and a further delay slot is armed.
- R5: On unit 0, an executed word with bit 61 set and no bit 63 writes the pending transfer (index and data) through `creg_we_o` in that cycle, and the pending flag clears on the next cycle. Without a pending transfer nothing is written.
- R6: An executed word with bit 60 set and `dbg_en_i` high, or with bit 59 set and `trap_en_i` high, stops the engine. `irq_o` pulses once on the next cycle. With the matching enable low, execution continues.
- R7: Register class encodings are 0 for the floating vector file, 1 for the integer file and 2 for a special register. When both halves request the same floating vector register, only the upper write is enabled. In every other case both requests are enabled.
- R8: While `stall_i` is high, or when the engine is neither running nor in a delay slot, nothing issues, no write is enabled and the address holds.
- R9: Each executed cycle advances the program counter by exactly one word.
- R10: After reset the engine is idle. A `start_i` pulse while it is not executing loads `start_pc_i` and raises `busy_o`. A pulse while it is executing is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse |
| start_pc_i | input | 16 | Program counter loaded on start |
| busy_o | output | 1 | Engine in run state |
| imem_addr_o | output | 12 | Micro-memory read address |
| imem_data_i | input | 64 | Micro-memory word at that address |
| stall_i | input | 1 | Data hazard hold |
| dbg_en_i | input | 1 | Debug-halt enable |
| trap_en_i | input | 1 | Trap-halt enable |
| upper_inst_o | output | 32 | Upper-pipe instruction |
| lower_inst_o | output | 32 | Lower-pipe instruction |
| upper_issue_o | output | 1 | Upper half executes this cycle |
| lower_issue_o | output | 1 | Lower half executes this cycle |
| imm_o | output | 32 | Immediate register |
| up_wr_en_i | input | 1 | Upper write request |
| up_wr_kind_i | input | 2 | Upper register class |
| up_wr_dst_i | input | 5 | Upper destination index |
| lo_wr_en_i | input | 1 | Lower write request |
| lo_wr_kind_i | input | 2 | Lower register class |
| lo_wr_dst_i | input | 5 | Lower destination index |
| up_we_o | output | 1 | Upper write enable |
| lo_we_o | output | 1 | Lower write enable |
| xfer_req_i | input | 1 | Coprocessor transfer request |
| xfer_idx_i | input | 5 | Transfer control-register index |
| xfer_data_i | input | 32 | Transfer data |
| xfer_pending_o | output | 1 | A transfer is waiting |
| creg_we_o | output | 1 | Control register write |
| creg_idx_o | output | 5 | Control register index |
| creg_data_o | output | 32 | Control register data |
| irq_o | output | 1 | Halt interrupt pulse |
| ebit_in_slot_o | output | 1 | End flag seen inside a delay slot |

## Verification
The instruction halves, issue strobes, write enables and the control-register write are combinational on the current word, so the bench checks them in the same cycle, after it drives inputs and before the next rising edge. The address, busy, immediate, pending flag, interrupt and slot flag come from registers and are due one edge later. The bench checks them two nanoseconds after that edge. The delay-slot checks follow the words over two and three edges to confirm when issue stops.

// File: rtl/vfc_pkg.sv
// Shared types and flag positions for the flag controller.
// Assumes a 64-bit microinstruction whose top five bits are control flags.
package vfc_pkg;

    // Run state of the engine
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_STOP = 2'd2
    } run_state_e;

    // Register class carried by a write request
    typedef enum logic [1:0] {
        RK_VEC = 2'd0,
        RK_INT = 2'd1,
        RK_SPC = 2'd2
    } reg_kind_e;

    // Decoded control flags of one word
    typedef struct packed {
        logic imm;   // load lower half as immediate
        logic fin;   // end after delay slot
        logic xfer;  // commit pending transfer (unit 0 only)
        logic dbg;   // debug halt request
        logic trap;  // trap halt request
    } uflags_t;

    // Offsets of the flags below the top bit of the word
    localparam int OFS_IMM  = 0;
    localparam int OFS_FIN  = 1;
    localparam int OFS_XFER = 2;
    localparam int OFS_DBG  = 3;
    localparam int OFS_TRAP = 4;

endpackage

// File: rtl/vfc_flag_decode.sv
// Splits a microinstruction into its halves and decodes the flag bits.
// Assumes flags sit in the top five bits; the transfer flag exists only
// on unit 0 and reads as zero on any other unit.
module vfc_flag_decode
    import vfc_pkg::*;
#(
    parameter int IW      = 64,
    parameter int UNIT_ID = 0,
    localparam int HW     = IW / 2
) (
    input  logic [IW-1:0] word_i,
    output uflags_t       flags_o,
    output logic [HW-1:0] upper_o,
    output logic [HW-1:0] lower_o
);

    localparam int TOP = IW - 1;

    logic xfer_bit;

    // Route the two halves to their pipes
    always_comb begin
        upper_o = word_i[IW-1:HW];
        lower_o = word_i[HW-1:0];
    end

    // Transfer flag honoured only on unit 0
    generate
        if (UNIT_ID == 0) begin : g_xfer_on
            assign xfer_bit = word_i[TOP-OFS_XFER];
        end else begin : g_xfer_off
            assign xfer_bit = 1'b0;
        end
    endgenerate

    // Assemble flag struct
    always_comb begin
        flags_o.imm  = word_i[TOP-OFS_IMM];
        flags_o.fin  = word_i[TOP-OFS_FIN];
        flags_o.xfer = xfer_bit;
        flags_o.dbg  = word_i[TOP-OFS_DBG];
        flags_o.trap = word_i[TOP-OFS_TRAP];
    end

endmodule

// File: rtl/vfc_write_arb.sv
// Arbitrates register writes between the upper and lower halves.
// Assumes requests are valid in the cycle the word executes; the upper
// half beats the lower half on a shared floating vector destination.
module vfc_write_arb
    import vfc_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic             fire_i,
    input  logic             lower_exec_i,
    input  logic             up_en_i,
    input  logic [1:0]       up_kind_i,
    input  logic [IDX_W-1:0] up_dst_i,
    input  logic             lo_en_i,
    input  logic [1:0]       lo_kind_i,
    input  logic [IDX_W-1:0] lo_dst_i,
    output logic             up_we_o,
    output logic             lo_we_o
);

    logic both_vec;
    logic same_dst;
    logic clash;

    // Detect a same-register clash in the floating vector file
    always_comb begin
        both_vec = (up_kind_i == RK_VEC) && (lo_kind_i == RK_VEC);
        same_dst = (up_dst_i == lo_dst_i);
        clash    = up_en_i && both_vec && same_dst;
    end

    // Grant enables; lower loses on a clash
    always_comb begin
        up_we_o = fire_i && up_en_i;
        lo_we_o = fire_i && lower_exec_i && lo_en_i && !clash;
    end

endmodule

// File: rtl/vfc_seq.sv
// Sequencer: run state, program counter, delay slot, immediate register,
// halt interrupt, slot-flag report and the pending coprocessor transfer.
// Assumes flags are already decoded and that a delay slot is one word.
module vfc_seq
    import vfc_pkg::*;
#(
    parameter int PCR_W  = 16,
    parameter int HW     = 32,
    parameter int CIDX_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [PCR_W-1:0]  start_pc_i,
    input  logic              stall_i,
    input  logic              dbg_en_i,
    input  logic              trap_en_i,
    input  uflags_t           flags_i,
    input  logic [HW-1:0]     lower_i,
    input  logic              xfer_req_i,
    input  logic [CIDX_W-1:0] xfer_idx_i,
    input  logic [HW-1:0]     xfer_data_i,
    output logic [PCR_W-1:0]  pc_o,
    output logic              busy_o,
    output logic              exec_o,
    output logic              fire_o,
    output logic              delay_pend_o,
    output logic [HW-1:0]     imm_o,
    output logic              irq_o,
    output logic              ebit_slot_o,
    output logic              xfer_pend_o,
    output logic              creg_we_o,
    output logic [CIDX_W-1:0] creg_idx_o,
    output logic [HW-1:0]     creg_data_o
);

    run_state_e          state_q;
    logic [PCR_W-1:0]    pc_q;
    logic                dly_q;
    logic [HW-1:0]       imm_q;
    logic                irq_q;
    logic                eslot_q;
    logic                xpend_q;
    logic [CIDX_W-1:0]   xidx_q;
    logic [HW-1:0]       xdata_q;

    logic exec;
    logic fire;
    logic halt;
    logic commit;

    // Execution qualifiers for the current cycle
    always_comb begin
        exec   = (state_q == ST_RUN) || dly_q;
        fire   = exec && !stall_i;
        halt   = (flags_i.dbg && dbg_en_i) || (flags_i.trap && trap_en_i);
        commit = fire && !flags_i.imm && flags_i.xfer && xpend_q;
    end

    // State, program counter, delay slot, immediate and report pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pc_q    <= '0;
            dly_q   <= 1'b0;
            imm_q   <= '0;
            irq_q   <= 1'b0;
            eslot_q <= 1'b0;
        end else begin
            irq_q   <= 1'b0;
            eslot_q <= 1'b0;
            if (start_i && !exec) begin
                state_q <= ST_RUN;
                pc_q    <= start_pc_i;
            end else if (fire) begin
                pc_q <= pc_q + 1'b1;
                if (flags_i.imm) begin
                    imm_q <= lower_i;
                    dly_q <= 1'b0;
                end else if (halt) begin
                    state_q <= ST_STOP;
                    dly_q   <= 1'b0;
                    irq_q   <= 1'b1;
                end else if (flags_i.fin) begin
                    state_q <= ST_IDLE;
                    dly_q   <= 1'b1;
                    eslot_q <= dly_q;
                end else begin
                    dly_q <= 1'b0;
                end
            end
        end
    end

    // Pending transfer: capture when empty, clear on commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xpend_q <= 1'b0;
            xidx_q  <= '0;
            xdata_q <= '0;
        end else if (commit) begin
            xpend_q <= 1'b0;
        end else if (xfer_req_i && !xpend_q) begin
            xpend_q <= 1'b1;
            xidx_q  <= xfer_idx_i;
            xdata_q <= xfer_data_i;
        end
    end

    // Drive outputs
    always_comb begin
        pc_o         = pc_q;
        busy_o       = (state_q == ST_RUN);
        exec_o       = exec;
        fire_o       = fire;
        delay_pend_o = dly_q;
        imm_o        = imm_q;
        irq_o        = irq_q;
        ebit_slot_o  = eslot_q;
        xfer_pend_o  = xpend_q;
        creg_we_o    = commit;
        creg_idx_o   = xidx_q;
        creg_data_o  = xdata_q;
    end

endmodule

// File: rtl/vliw_flag_ctrl.sv
// Top of the dual-issue flag controller. Fetches at the masked program
// counter, decodes flags, sequences the engine and arbitrates writes.
// Assumes micro-memory returns the word for imem_addr_o in the same cycle.
module vliw_flag_ctrl
    import vfc_pkg::*;
#(
    parameter int UNIT_ID = 0,
    parameter int IW      = 64,
    parameter int PCR_W   = 16,
    parameter int ADDR_W  = 12,
    parameter int IDX_W   = 5,
    parameter int CIDX_W  = 5,
    localparam int HW     = IW / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [PCR_W-1:0]  start_pc_i,
    output logic              busy_o,
    output logic [ADDR_W-1:0] imem_addr_o,
    input  logic [IW-1:0]     imem_data_i,
    input  logic              stall_i,
    input  logic              dbg_en_i,
    input  logic              trap_en_i,
    output logic [HW-1:0]     upper_inst_o,
    output logic [HW-1:0]     lower_inst_o,
    output logic              upper_issue_o,
    output logic              lower_issue_o,
    output logic [HW-1:0]     imm_o,
    input  logic              up_wr_en_i,
    input  logic [1:0]        up_wr_kind_i,
    input  logic [IDX_W-1:0]  up_wr_dst_i,
    input  logic              lo_wr_en_i,
    input  logic [1:0]        lo_wr_kind_i,
    input  logic [IDX_W-1:0]  lo_wr_dst_i,
    output logic              up_we_o,
    output logic              lo_we_o,
    input  logic              xfer_req_i,
    input  logic [CIDX_W-1:0] xfer_idx_i,
    input  logic [HW-1:0]     xfer_data_i,
    output logic              xfer_pending_o,
    output logic              creg_we_o,
    output logic [CIDX_W-1:0] creg_idx_o,
    output logic [HW-1:0]     creg_data_o,
    output logic              irq_o,
    output logic              ebit_in_slot_o
);

    uflags_t          flags;
    logic [HW-1:0]    upper_half;
    logic [HW-1:0]    lower_half;
    logic [PCR_W-1:0] pc;
    logic             exec;
    logic             fire;
    logic             delay_pend;

    // Fetch address is the masked program counter
    always_comb imem_addr_o = pc[ADDR_W-1:0];

    vfc_flag_decode #(.IW(IW), .UNIT_ID(UNIT_ID)) u_dec (
        .word_i  (imem_data_i),
        .flags_o (flags),
        .upper_o (upper_half),
        .lower_o (lower_half)
    );

    vfc_seq #(.PCR_W(PCR_W), .HW(HW), .CIDX_W(CIDX_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .start_pc_i   (start_pc_i),
        .stall_i      (stall_i),
        .dbg_en_i     (dbg_en_i),
        .trap_en_i    (trap_en_i),
        .flags_i      (flags),
        .lower_i      (lower_half),
        .xfer_req_i   (xfer_req_i),
        .xfer_idx_i   (xfer_idx_i),
        .xfer_data_i  (xfer_data_i),
        .pc_o         (pc),
        .busy_o       (busy_o),
        .exec_o       (exec),
        .fire_o       (fire),
        .delay_pend_o (delay_pend),
        .imm_o        (imm_o),
        .irq_o        (irq_o),
        .ebit_slot_o  (ebit_in_slot_o),
        .xfer_pend_o  (xfer_pending_o),
        .creg_we_o    (creg_we_o),
        .creg_idx_o   (creg_idx_o),
        .creg_data_o  (creg_data_o)
    );

    vfc_write_arb #(.IDX_W(IDX_W)) u_arb (
        .fire_i       (fire),
        .lower_exec_i (!flags.imm),
        .up_en_i      (up_wr_en_i),
        .up_kind_i    (up_wr_kind_i),
        .up_dst_i     (up_wr_dst_i),
        .lo_en_i      (lo_wr_en_i),
        .lo_kind_i    (lo_wr_kind_i),
        .lo_dst_i     (lo_wr_dst_i),
        .up_we_o      (up_we_o),
        .lo_we_o      (lo_we_o)
    );

    // Instruction routing and issue strobes
    always_comb begin
        upper_inst_o  = upper_half;
        lower_inst_o  = lower_half;
        upper_issue_o = fire;
        lower_issue_o = fire && !flags.imm;
    end

endmodule

// File: rtl/vfc_checker.sv
// Temporal checks on the flag controller, bound to every instance.
// Assumes the bound instance exposes exec and delay_pend internally.
module vfc_checker #(
    parameter int ADDR_W = 12,
    parameter int IW     = 64,
    parameter int IDX_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_o,
    input logic              delay_pend,
    input logic              stall_i,
    input logic [ADDR_W-1:0] imem_addr_o,
    input logic [IW-1:0]     imem_data_i,
    input logic              upper_issue_o,
    input logic              lower_issue_o,
    input logic              up_we_o,
    input logic              lo_we_o,
    input logic [1:0]        up_wr_kind_i,
    input logic [1:0]        lo_wr_kind_i,
    input logic [IDX_W-1:0]  up_wr_dst_i,
    input logic [IDX_W-1:0]  lo_wr_dst_i,
    input logic              creg_we_o,
    input logic              xfer_pending_o,
    input logic              irq_o
);

    AST_IDLE_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !delay_pend) |-> (!upper_issue_o && !up_we_o && !lo_we_o)); // R8

    AST_STALL_HOLDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        ((busy_o || delay_pend) && stall_i) |=> $stable(imem_addr_o)); // R8

    AST_ADVANCE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        upper_issue_o |=> (imem_addr_o == ADDR_W'($past(imem_addr_o) + 1'b1))); // R9

    AST_IMM_NO_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
        (upper_issue_o && imem_data_i[IW-1]) |-> (!lower_issue_o && !lo_we_o)); // R2

    AST_VEC_CLASH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (up_we_o && up_wr_kind_i == 2'd0 && lo_wr_kind_i == 2'd0
         && up_wr_dst_i == lo_wr_dst_i) |-> !lo_we_o); // R7

    AST_COMMIT_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        creg_we_o |-> xfer_pending_o); // R5

    AST_COMMIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        creg_we_o |=> !xfer_pending_o); // R5

    AST_IRQ_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> !busy_o); // R6

endmodule

bind vliw_flag_ctrl vfc_checker #(.ADDR_W(ADDR_W), .IW(IW), .IDX_W(IDX_W)) u_vfc_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .busy_o         (busy_o),
    .delay_pend     (delay_pend),
    .stall_i        (stall_i),
    .imem_addr_o    (imem_addr_o),
    .imem_data_i    (imem_data_i),
    .upper_issue_o  (upper_issue_o),
    .lower_issue_o  (lower_issue_o),
    .up_we_o        (up_we_o),
    .lo_we_o        (lo_we_o),
    .up_wr_kind_i   (up_wr_kind_i),
    .lo_wr_kind_i   (lo_wr_kind_i),
    .up_wr_dst_i    (up_wr_dst_i),
    .lo_wr_dst_i    (lo_wr_dst_i),
    .creg_we_o      (creg_we_o),
    .xfer_pending_o (xfer_pending_o),
    .irq_o          (irq_o)
);

// File: tb/vliw_flag_ctrl_bench.sv
// Self-checking bench for the flag controller; a 64-word array stands in
// for micro-memory, indexed by the low address bits.
module vliw_flag_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] start_pc_i = '0;
    logic        busy_o;
    logic [11:0] imem_addr_o;
    logic [63:0] imem_data_i;
    logic        stall_i = 1'b0;
    logic        dbg_en_i = 1'b0;
    logic        trap_en_i = 1'b0;
    logic [31:0] upper_inst_o, lower_inst_o, imm_o;
    logic        upper_issue_o, lower_issue_o;
    logic        up_wr_en_i = 1'b0, lo_wr_en_i = 1'b0;
    logic [1:0]  up_wr_kind_i = '0, lo_wr_kind_i = '0;
    logic [4:0]  up_wr_dst_i = '0, lo_wr_dst_i = '0;
    logic        up_we_o, lo_we_o;
    logic        xfer_req_i = 1'b0;
    logic [4:0]  xfer_idx_i = '0;
    logic [31:0] xfer_data_i = '0;
    logic        xfer_pending_o, creg_we_o;
    logic [4:0]  creg_idx_o;
    logic [31:0] creg_data_o;
    logic        irq_o, ebit_in_slot_o;

    logic [63:0] rom [0:63];
    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    assign imem_data_i = rom[imem_addr_o[5:0]];

    vliw_flag_ctrl u_vliw_flag_ctrl (.*);

    function automatic logic [63:0] plain(input int i);
        return {32'h0100_0000 + 32'(i), 32'h5500_0000 + 32'(i)};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic do_start(input logic [15:0] pc);
        start_i = 1'b1;
        start_pc_i = pc;
        step();
        start_i = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired act=hung exp=done");
        finish_run();
    end

    initial begin
        logic [11:0] a;
        for (int i = 0; i < 64; i++) rom[i] = plain(i);
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // Reset state R10, idle R8
        check("R10 reset busy", busy_o, 0);
        check("R8 reset issue", upper_issue_o, 0);
        check("R6 reset irq", irq_o, 0);
        check("R5 reset pending", xfer_pending_o, 0);

        // Start with upper address bits set: R1 masking, R10 busy
        do_start(16'h1005);
        check("R10 busy after start", busy_o, 1);
        check("R1 masked address", imem_addr_o, 12'h005);
        check("R1 upper half", upper_inst_o, rom[5][63:32]);
        check("R1 lower half", lower_inst_o, rom[5][31:0]);
        for (int k = 0; k < 4; k++) begin
            a = imem_addr_o;
            check("R9 issue while running", upper_issue_o, 1);
            step();
            check("R9 advance by one", imem_addr_o, a + 12'd1);
        end

        // Start ignored while executing R10
        a = imem_addr_o;
        start_i = 1'b1;
        start_pc_i = 16'h0033;
        step();
        start_i = 1'b0;
        check("R10 start ignored when busy", imem_addr_o, a + 12'd1);

        // Stall holds R8
        stall_i = 1'b1;
        up_wr_en_i = 1'b1;
        a = imem_addr_o;
        #1;
        check("R8 no issue on stall", upper_issue_o, 0);
        check("R8 no write on stall", up_we_o, 0);
        step();
        step();
        check("R8 address held on stall", imem_addr_o, a);
        stall_i = 1'b0;
        up_wr_en_i = 1'b0;

        // Immediate flag R2
        a = imem_addr_o;
        rom[a[5:0]] = {1'b1, 31'h0000_0042, 32'hCAFE_1234};
        lo_wr_en_i = 1'b1;
        lo_wr_kind_i = 2'd1;
        #1;
        check("R2 upper issues", upper_issue_o, 1);
        check("R2 lower not issued", lower_issue_o, 0);
        check("R2 lower write blocked", lo_we_o, 0);
        step();
        check("R2 immediate latched", imm_o, 32'hCAFE_1234);
        check("R2 pc advanced", imem_addr_o, a + 12'd1);
        rom[a[5:0]] = plain(int'(a[5:0]));
        lo_wr_en_i = 1'b0;

        // Write arbitration sweep R7: classes 0 vec, 1 int, 2 special
        for (int uk = 0; uk < 3; uk++) begin
            for (int lk = 0; lk < 3; lk++) begin
                for (int sd = 0; sd < 2; sd++) begin
                    up_wr_en_i = 1'b1;
                    lo_wr_en_i = 1'b1;
                    up_wr_kind_i = 2'(uk);
                    lo_wr_kind_i = 2'(lk);
                    up_wr_dst_i = 5'd3;
                    lo_wr_dst_i = (sd != 0) ? 5'd3 : 5'd7;
                    #1;
                    check("R7 upper enable", up_we_o, 1);
                    check("R7 lower enable", lo_we_o,
                          (uk == 0 && lk == 0 && sd != 0) ? 0 : 1);
                    step();
                end
            end
        end
        up_wr_en_i = 1'b0;
        lo_wr_en_i = 1'b0;

        // Debug flag with enable low: continues R6
        a = imem_addr_o;
        rom[a[5:0]] = plain(int'(a[5:0])) | (64'd1 << 60);
        dbg_en_i = 1'b0;
        trap_en_i = 1'b1;
        step();
        check("R6 dbg disabled keeps running", busy_o, 1);
        check("R6 no irq when disabled", irq_o, 0);
        rom[a[5:0]] = plain(int'(a[5:0]));

        // Trap flag with enable low: continues R6
        a = imem_addr_o;
        rom[a[5:0]] = plain(int'(a[5:0])) | (64'd1 << 59);
        dbg_en_i = 1'b1;
        trap_en_i = 1'b0;
        step();
        check("R6 trap disabled keeps running", busy_o, 1);
        check("R6 no irq for trap disabled", irq_o, 0);
        rom[a[5:0]] = plain(int'(a[5:0]));

        // Trap flag enabled: halts R6
        a = imem_addr_o;
        rom[a[5:0]] = plain(int'(a[5:0])) | (64'd1 << 59);
        trap_en_i = 1'b1;
        step();
        check("R6 trap halts", busy_o, 0);
        check("R6 trap irq", irq_o, 1);
        check("R8 stopped no issue", upper_issue_o, 0);
        step();
        check("R6 irq single pulse", irq_o, 0);
        check("R8 stopped address held", imem_addr_o, a + 12'd1);
        rom[a[5:0]] = plain(int'(a[5:0]));

        // Debug flag enabled: halts R6
        do_start(16'h0030);
        rom[6'h30] = plain(6'h30) | (64'd1 << 60);
        #1;
        step();
        check("R6 debug halts", busy_o, 0);
        check("R6 debug irq", irq_o, 1);
        rom[6'h30] = plain(6'h30);
        dbg_en_i = 1'b0;
        trap_en_i = 1'b0;

        // End flag and delay slot R3
        rom[6'h10] = plain(6'h10) | (64'd1 << 62);
        do_start(16'h0010);
        check("R3 end word issues", upper_issue_o, 1);
        step();
        check("R3 busy drops", busy_o, 0);
        check("R3 delay slot issues", upper_issue_o, 1);
        check("R3 delay slot word", upper_inst_o, rom[6'h11][63:32]);
        check("R4 no slot flag on plain end", ebit_in_slot_o, 0);
        step();
        check("R3 nothing after slot", upper_issue_o, 0);
        check("R3 address after slot", imem_addr_o, 12'h012);
        step();
        check("R3 address held", imem_addr_o, 12'h012);
        rom[6'h10] = plain(6'h10);

        // End flag inside the delay slot R4
        rom[6'h18] = plain(6'h18) | (64'd1 << 62);
        rom[6'h19] = plain(6'h19) | (64'd1 << 62);
        do_start(16'h0018);
        step();
        check("R4 first end no flag", ebit_in_slot_o, 0);
        step();
        check("R4 slot flag pulses", ebit_in_slot_o, 1);
        check("R4 slot re-armed", upper_issue_o, 1);
        step();
        check("R4 slot flag clears", ebit_in_slot_o, 0);
        check("R4 engine quiet", upper_issue_o, 0);
        rom[6'h18] = plain(6'h18);
        rom[6'h19] = plain(6'h19);

        // Transfer commit R5
        do_start(16'h0028);
        xfer_req_i = 1'b1;
        xfer_idx_i = 5'd9;
        xfer_data_i = 32'hDEAD_BEEF;
        step();
        xfer_req_i = 1'b0;
        check("R5 transfer pending", xfer_pending_o, 1);
        rom[6'h29] = plain(6'h29) | (64'd1 << 63) | (64'd1 << 61);
        #1;
        check("R5 immediate word blocks commit", creg_we_o, 0);
        step();
        check("R5 still pending", xfer_pending_o, 1);
        rom[6'h2A] = plain(6'h2A) | (64'd1 << 61);
        #1;
        check("R5 commit write", creg_we_o, 1);
        check("R5 commit index", creg_idx_o, 5'd9);
        check("R5 commit data", creg_data_o, 32'hDEAD_BEEF);
        step();
        check("R5 pending cleared", xfer_pending_o, 0);
        rom[6'h2B] = plain(6'h2B) | (64'd1 << 61);
        #1;
        check("R5 no commit without pending", creg_we_o, 0);
        step();
        rom[6'h2C] = plain(6'h2C) | (64'd1 << 60);
        dbg_en_i = 1'b1;
        step();
        check("R6 final halt", busy_o, 0);

        finish_run();
    end

endmodule